// File: doc/BRIEF.md
# Configurable Edge and Level Interrupt Bank

This block watches eight external signals and raises one interrupt line when any enabled channel sees its chosen trigger. Each input passes through a two-flop synchroniser on a slow capture clock (nominally 32 kHz, unrelated to the bus clock). Each channel is set on its own to fire on a rising edge, a falling edge, any transition, a high level or a low level. The trigger comes from three control bits per channel: a mode bit, a polarity bit and a both-edge bit that overrides the other two.

A detected event crosses into the bus clock domain over a per-channel toggle handshake. If an event occurs while a crossing is still in flight, it is held until that crossing finishes, so no event is lost. On the bus side, events set a sticky raw status bit. Software clears that bit by writing a 1 to it. The masked status is raw status gated by the enable bits, and the interrupt line is the OR of the masked status.

Software uses a simple 32-bit register port on the bus clock. Word offsets are decoded from the address. A write takes effect on the clock edge where the write strobe is high. Read data is combinational on the address.

Top module: `irq_edge_bank`

## Requirements
- R1: Bit i of every register belongs to channel i (i = 0..7), and bits 31:8 read 0. The word offsets are: enable 0x00, raw status 0x04, masked status 0x08, clear 0x0C (reads 0), mode 0x10, both-edge 0x14, polarity 0x18, sampled data 0x1C. Every register reads 0 after reset.
- R2: With mode = 0, both-edge = 0 and polarity = 1, a 0-to-1 transition of the sampled input sets raw status, and a 1-to-0 transition does not.
- R3: With mode = 0, both-edge = 0 and polarity = 0, a 1-to-0 transition sets raw status, and a 0-to-1 transition does not.
- R4: With both-edge = 1, every transition sets raw status, whatever the mode and polarity bits hold.
- R5: With mode = 1 and both-edge = 0, raw status is set while the sampled input equals the polarity bit (1 = high, 0 = low). If the level is still active after a clear, the bit is set again on a later sample.
- R6: Writing to the clear offset drops exactly the raw bits written as 1, one bus cycle later. Bits written as 0 are untouched. An event arriving in the same cycle as its clear wins.
- R7: Masked status equals raw status AND enable. The interrupt line is high exactly when masked status is non-zero. Enable never changes raw status.
- R8: The sampled-data offset returns the synchronised input levels.
- R9: A pulse lasting one capture-clock period is caught in edge mode. Events that occur while a channel's crossing is busy are held and delivered afterwards.
- R10: Writes to the raw, masked and sampled-data offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| capClk | input | 1 | Slow capture clock used to sample the inputs |
| chanIn | input | 8 | External signals to watch |
| busAddr | input | 5 | Byte address of the register word |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| irqOut | output | 1 | Combined interrupt line |

## Verification
The bench drives a mixed configuration: all five trigger types, plus a channel whose both-edge bit overrides a level setting. Its model predicts the settled raw status after each input step, so a swapped polarity or an ignored both-edge override shows up as a wrong bit.

It pulses inputs for exactly one capture period. A detector that compared the wrong pair of samples would miss these pulses. It also clears a channel whose low level is still active, and checks that the bit comes back; a design that treated level mode as an edge would leave it clear.

A selective clear checks that only the written bits drop. A design that cleared the whole word, or ignored the data, would be caught there. Writes to the read-only offsets must leave every register intact.

// File: rtl/ieb_pkg.sv
package ieb_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 5;

  // word index = byte address bits 4:2; software depends on this order
  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_RAW    = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_CLEAR  = 3'd3,
    SEL_MODE   = 3'd4,
    SEL_BOTH   = 3'd5,
    SEL_POL    = 3'd6,
    SEL_DATA   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrEnable;
    logic    wrMode;
    logic    wrBoth;
    logic    wrPol;
    logic    wrClear;
    regSel_e rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/ieb_sync.sv
module ieb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/ieb_capture.sv
module ieb_capture #(
  parameter int unsigned N = 8
) (
  input  logic         capClk,
  input  logic         rstN,
  input  logic [N-1:0] chanIn,
  input  logic [N-1:0] modeB,
  input  logic [N-1:0] bothB,
  input  logic [N-1:0] polB,
  input  logic [N-1:0] ackTog,
  output logic [N-1:0] reqTog,
  output logic [N-1:0] sampled
);
  localparam int unsigned CFG_W = 3 * N;

  logic [CFG_W-1:0] cfgSync;
  logic [N-1:0] modeC, bothC, polC;
  logic [N-1:0] prevSmp, ackSync, evt, pend, busy, fire;

  ieb_sync #(.W(CFG_W)) uCfgSync (
    .clk(capClk), .rstN(rstN),
    .asyncIn({modeB, bothB, polB}), .syncOut(cfgSync)
  );
  assign {modeC, bothC, polC} = cfgSync;

  ieb_sync #(.W(N)) uInSync (
    .clk(capClk), .rstN(rstN), .asyncIn(chanIn), .syncOut(sampled)
  );

  ieb_sync #(.W(N)) uAckSync (
    .clk(capClk), .rstN(rstN), .asyncIn(ackTog), .syncOut(ackSync)
  );

  always_ff @(posedge capClk or negedge rstN) begin
    if (!rstN) prevSmp <= '0;
    else       prevSmp <= sampled;
  end

  for (genvar i = 0; i < N; i++) begin : gDetect
    logic rise, fall, edgeHit, levelHit;
    assign rise     = sampled[i] & ~prevSmp[i];
    assign fall     = ~sampled[i] & prevSmp[i];
    assign edgeHit  = polC[i] ? rise : fall;
    assign levelHit = ~(sampled[i] ^ polC[i]);
    assign evt[i]   = bothC[i] ? (rise | fall)
                               : (modeC[i] ? levelHit : edgeHit);
  end

  // a crossing is in flight until the bus side echoes the toggle back
  assign busy = reqTog ^ ackSync;
  assign fire = (evt | pend) & ~busy;

  always_ff @(posedge capClk or negedge rstN) begin
    if (!rstN) begin
      reqTog <= '0;
      pend   <= '0;
    end else begin
      reqTog <= reqTog ^ fire;
      pend   <= (pend | evt) & ~fire;
    end
  end

  // R9: a request toggle never moves while its crossing is busy
  p_no_toggle_while_busy_r9: assert property (@(posedge capClk) disable iff (!rstN)
    1'b1 |=> ((reqTog ^ $past(reqTog)) & $past(busy)) == '0);
endmodule

// File: rtl/ieb_ctrl.sv
module ieb_ctrl
  import ieb_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobes_t       st
);
  regSel_e sel;
  logic [1:0] unusedLow;

  assign unusedLow = busAddr[1:0];
  assign sel       = regSel_e'(busAddr[ADDR_W-1:2]);

  always_comb begin
    st          = '0;
    st.rdSel    = sel;
    st.wrEnable = busWrEn && (sel == SEL_ENABLE);
    st.wrClear  = busWrEn && (sel == SEL_CLEAR);
    st.wrMode   = busWrEn && (sel == SEL_MODE);
    st.wrBoth   = busWrEn && (sel == SEL_BOTH);
    st.wrPol    = busWrEn && (sel == SEL_POL);
  end
endmodule

// File: rtl/ieb_regs.sv
module ieb_regs
  import ieb_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      st,
  input  logic [N-1:0]     wdata,
  input  logic [N-1:0]     reqSync,
  input  logic [N-1:0]     dataSync,
  output logic [N-1:0]     ackTog,
  output logic [N-1:0]     modeQ,
  output logic [N-1:0]     bothQ,
  output logic [N-1:0]     polQ,
  output logic [BUS_W-1:0] rdData,
  output logic             irq
);
  logic [N-1:0] enQ, rawQ, maskedQ, setPls, clrMask;

  // ackTog is the last toggle seen; a change against it is a new event
  assign setPls  = reqSync ^ ackTog;
  assign clrMask = st.wrClear ? wdata : '0;
  assign maskedQ = rawQ & enQ;
  assign irq     = |maskedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackTog <= '0;
      rawQ   <= '0;
      enQ    <= '0;
      modeQ  <= '0;
      bothQ  <= '0;
      polQ   <= '0;
    end else begin
      ackTog <= reqSync;
      rawQ   <= (rawQ & ~clrMask) | setPls;
      if (st.wrEnable) enQ   <= wdata;
      if (st.wrMode)   modeQ <= wdata;
      if (st.wrBoth)   bothQ <= wdata;
      if (st.wrPol)    polQ  <= wdata;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (st.rdSel)
      SEL_ENABLE: rdData[N-1:0] = enQ;
      SEL_RAW:    rdData[N-1:0] = rawQ;
      SEL_MASKED: rdData[N-1:0] = maskedQ;
      SEL_CLEAR:  rdData[N-1:0] = '0;
      SEL_MODE:   rdData[N-1:0] = modeQ;
      SEL_BOTH:   rdData[N-1:0] = bothQ;
      SEL_POL:    rdData[N-1:0] = polQ;
      SEL_DATA:   rdData[N-1:0] = dataSync;
      default:    rdData = '0;
    endcase
  end

  // R2: a delivered event shows in raw status on the next cycle
  p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (setPls != '0) |=> ((rawQ & $past(setPls)) == $past(setPls)));

  // R6: written clear bits are gone a cycle later unless an event arrived
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.wrClear |=> ((rawQ & $past(clrMask & ~setPls)) == '0));

  // R6: without a clear, raw status never loses a bit
  p_raw_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrClear |=> ((rawQ & $past(rawQ)) == $past(rawQ)));

  // R10: enable only changes on a write to its own offset
  p_enable_guarded_r10: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrEnable |=> $stable(enQ));
endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank
  import ieb_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capClk,
  input  logic [N-1:0]      chanIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdData,
  output logic              irqOut
);
  ctlStrobes_t st;
  logic [N-1:0] modeQ, bothQ, polQ, ackTog, reqTog, reqSync, sampled, dataSync;
  logic [BUS_W-N-1:0] unusedWdata;

  assign unusedWdata = busWdata[BUS_W-1:N];

  ieb_ctrl uCtrl (.busAddr(busAddr), .busWrEn(busWrEn), .st(st));

  ieb_capture #(.N(N)) uCap (
    .capClk(capClk), .rstN(rstN), .chanIn(chanIn),
    .modeB(modeQ), .bothB(bothQ), .polB(polQ),
    .ackTog(ackTog), .reqTog(reqTog), .sampled(sampled)
  );

  ieb_sync #(.W(N)) uReqSync (
    .clk(clk), .rstN(rstN), .asyncIn(reqTog), .syncOut(reqSync)
  );

  ieb_sync #(.W(N)) uDataSync (
    .clk(clk), .rstN(rstN), .asyncIn(sampled), .syncOut(dataSync)
  );

  ieb_regs #(.N(N)) uRegs (
    .clk(clk), .rstN(rstN), .st(st), .wdata(busWdata[N-1:0]),
    .reqSync(reqSync), .dataSync(dataSync), .ackTog(ackTog),
    .modeQ(modeQ), .bothQ(bothQ), .polQ(polQ),
    .rdData(busRdData), .irq(irqOut)
  );
endmodule

// File: tb/irq_edge_bank_test.sv
module irq_edge_bank_test;
  logic        clk = 1'b0;
  logic        capClk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  chanIn = '0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  // reference state
  logic [7:0] mEn = '0, mMode = '0, mBoth = '0, mPol = '0, mIn = '0, mRaw = '0;

  always #5 clk = ~clk;
  always #80 capClk = ~capClk;

  irq_edge_bank uut (
    .clk(clk), .rstN(rstN), .capClk(capClk), .chanIn(chanIn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWdata(busWdata),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles exp fewer than 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [7:0] levelAct(input logic [7:0] v);
    return mMode & ~mBoth & ~(v ^ mPol);
  endfunction

  function automatic logic [7:0] events(input logic [7:0] o, input logic [7:0] n);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (mBoth[i])      r[i] = o[i] ^ n[i];
      else if (mMode[i]) r[i] = ~(n[i] ^ mPol[i]);
      else               r[i] = mPol[i] ? (n[i] & ~o[i]) : (o[i] & ~n[i]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (220) @(posedge clk);
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic checkStatus(input string tag);
    logic [31:0] d;
    busRead(5'h04, d); check({tag, " raw"}, d, {24'h0, mRaw});
    busRead(5'h08, d); check({tag, " masked R7"}, d, {24'h0, mRaw & mEn});
    check({tag, " irq R7"}, {31'h0, irqOut}, {31'h0, |(mRaw & mEn)});
    busRead(5'h1C, d); check({tag, " data R8"}, d, {24'h0, mIn});
  endtask

  task automatic clearAll();
    busWrite(5'h0C, 32'hFF);
    settle();
    mRaw = levelAct(mIn);
  endtask

  task automatic applyInput(input logic [7:0] v);
    logic [7:0] ev;
    ev = events(mIn, v);
    mIn = v;
    chanIn = v;
    settle();
    mRaw = mRaw | ev | levelAct(mIn);
  endtask

  task automatic setConfig(input logic [7:0] m, input logic [7:0] b, input logic [7:0] p);
    busWrite(5'h10, {24'h0, m}); mMode = m;
    busWrite(5'h14, {24'h0, b}); mBoth = b;
    busWrite(5'h18, {24'h0, p}); mPol = p;
    settle();
    clearAll();
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0] lvl;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    settle();

    // R1: every offset reads zero after reset
    for (int k = 0; k < 8; k++) begin
      busRead(5'(k * 4), d);
      check("reset state R1", d, 32'h0);
    end

    busWrite(5'h00, 32'hFF); mEn = 8'hFF;
    busRead(5'h00, d); check("enable readback R1", d, 32'h0000_00FF);
    // ch0 rise, ch1 fall, ch2 both, ch3 high, ch4 low, ch5 rise, ch6 fall, ch7 both over level
    setConfig(8'h98, 8'h84, 8'h29);
    busRead(5'h10, d); check("mode readback R1", d, 32'h98);
    busRead(5'h18, d); check("pol readback R1", d, 32'h29);
    busRead(5'h0C, d); check("clear reads zero R1", d, 32'h0);
    checkStatus("low level idle R5");

    applyInput(8'hFF); checkStatus("rise step R2 R4 R5");
    // R6: selective clear of ch0 and ch2, checked one cycle later
    lvl = levelAct(mIn);
    busWrite(5'h0C, 32'h05);
    busRead(5'h04, d);
    check("selective clear R6", d & {24'h0, ~lvl}, {24'h0, mRaw & ~8'h05 & ~lvl});
    mRaw = mRaw & ~8'h05;
    settle();
    mRaw = mRaw | levelAct(mIn);
    checkStatus("after selective clear R6");

    clearAll(); applyInput(8'h0F); checkStatus("upper fall R3 R4");
    clearAll(); applyInput(8'hF0); checkStatus("mixed step R2 R3");
    clearAll(); applyInput(8'h00); checkStatus("all fall R3 R5");
    // R5: ch4 low level re-asserts after clear
    clearAll(); checkStatus("level re-set R5");
    busRead(5'h04, d); check("ch4 back after clear R5", {31'h0, d[4]}, 32'h1);

    // R7: partial enable
    busWrite(5'h00, 32'h0A); mEn = 8'h0A;
    applyInput(8'h06); checkStatus("partial enable R7");
    busWrite(5'h00, 32'h10); mEn = 8'h10;
    checkStatus("enable on level ch R7");

    // R10: writes to read-only offsets
    busWrite(5'h04, 32'hFF); busWrite(5'h08, 32'hFF); busWrite(5'h1C, 32'hFF);
    busRead(5'h00, d); check("enable kept R10", d, 32'h10);
    busRead(5'h14, d); check("both kept R10", d, 32'h84);
    checkStatus("status kept R10");

    // R9: one capture-period pulses, rising edge mode on all channels
    busWrite(5'h00, 32'hFF); mEn = 8'hFF;
    setConfig(8'h00, 8'h00, 8'hFF);
    applyInput(8'h00); clearAll();
    @(negedge capClk) chanIn = 8'h01;
    @(negedge capClk) chanIn = 8'h00;
    settle();
    mRaw = 8'h01;
    checkStatus("short high pulse R9 R2");

    applyInput(8'hFF);
    setConfig(8'h00, 8'h00, 8'h00);
    @(negedge capClk) chanIn = 8'hF0;
    @(negedge capClk) chanIn = 8'hFF;
    settle();
    mRaw = 8'h0F;
    checkStatus("short low pulse R9 R3");

    // R4: both-edge overrides a level setting with polarity low
    setConfig(8'hFF, 8'hFF, 8'h00);
    checkStatus("both over level idle R4");
    applyInput(8'h3C); checkStatus("both over level step R4");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule